// File: doc/BRIEF.md
# Multi-Register Stack Push/Pull Sequencer

This block carries out the multi-register push and pull instructions of a small 8-bit processor core. When `start` is raised in an idle cycle with one of four stack opcodes, it captures the opcode and a register-select mask byte. It then walks the selected registers in a fixed priority order and moves them one byte per cycle between the register file and a byte-wide memory port. The opcode chooses between two 16-bit stack pointers, S and U.

The register file sits inside the block. It holds four 8-bit registers (A, B, CC, DP) and five 16-bit registers (X, Y, U, S, PC). The surrounding core writes these registers through a load port and sees every register on a dedicated output. The length of each instruction depends on the mask: a fixed overhead plus one cycle per byte moved. The block reports that total as soon as the instruction is accepted.

Top module: `stk_pushpull`

## Requirements
- R1: `start` is accepted only in an idle cycle and only with opcode 0x34 (push on S), 0x35 (pull from S), 0x36 (push on U) or 0x37 (pull from U). Any other opcode, or any `start` while `busy` is high, changes nothing.
- R2: An accepted instruction keeps `busy` high for exactly 5 + N cycles, starting at the clock edge that accepts it. N is the number of bytes moved. `done` is high only in the last of those cycles, and `cycles` shows 5 + N from the first busy cycle onward.
- R3: Mask bit positions select registers as follows: bit0 CC, bit1 A, bit2 B, bit3 DP, bit4 X, bit5 Y, bit6 the stack pointer not in use, bit7 PC. Bits 4 to 7 each move two bytes and bits 0 to 3 each move one.
- R4: A push visits the selected registers from bit7 down to bit0. Each byte is written at one below the current pointer, and the pointer then steps down by one. A 16-bit register gives its low byte first and its high byte second. Memory writes happen in busy cycles 5 to 4+N (counting the accepting edge as cycle 1).
- R5: A pull visits the selected registers from bit0 up to bit7. Each byte is read at the current pointer, and the pointer then steps up by one. For a 16-bit register the first byte read becomes the high byte. `mem_we` stays low throughout a pull.
- R6: The active stack pointer ends the instruction decremented (push) or incremented (pull) by N, and the new value is visible the cycle after `done`.
- R7: A mask of 0x00 completes in 5 cycles with no memory write and with every register unchanged.
- R8: Bit6 moves U when the S stack is in use and S when the U stack is in use, on both push and pull.
- R9: A load-port write (`ld_sel`: 0 CC, 1 A, 2 B, 3 DP, 4 X, 5 Y, 6 U, 7 S, 8 PC) takes effect at the next edge when the block is idle. It is ignored while `busy` is high. 8-bit targets keep the low byte of `ld_data`.
- R10: After reset, `busy`, `done`, `mem_we` and `cycles` are 0 and all registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin an instruction |
| opcode | input | 8 | Stack instruction opcode |
| postbyte | input | 8 | Register-select mask |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Final cycle of the instruction |
| cycles | output | 5 | Total cycle count of the current or last instruction |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 8 | Byte to write |
| mem_we | output | 1 | Write strobe |
| mem_rdata | input | 8 | Byte read at `mem_addr` in the same cycle |
| ld_en | input | 1 | Register load strobe |
| ld_sel | input | 4 | Register to load |
| ld_data | input | 16 | Load value |
| reg_a | output | 8 | Register A |
| reg_b | output | 8 | Register B |
| reg_cc | output | 8 | Register CC |
| reg_dp | output | 8 | Register DP |
| reg_x | output | 16 | Register X |
| reg_y | output | 16 | Register Y |
| reg_u | output | 16 | User stack pointer |
| reg_s | output | 16 | System stack pointer |
| reg_pc | output | 16 | Program counter |

## Verification
The hardest situation to reach from the ports is a second request arriving while an instruction is running. This covers both a new `start` and a register load that lands mid-sequence, before the byte that would read the loaded register. The stimulus drives both a few cycles after acceptance and checks, cycle by cycle against a behavioural model, that the addresses, the written bytes and the final registers are unaffected. A sweep over every single-bit mask on the U stack, each pull preceded by a clobbering load, covers the bit-to-register mapping, including bit6 selecting S.

// File: rtl/stk_pkg.sv
package stk_pkg;
  localparam int NUM_RID = 9;
  localparam int MASK_W  = 8;
  localparam int NUM_NARROW = 4;

  typedef enum logic [3:0] {
    RID_CC = 4'd0, RID_A = 4'd1, RID_B = 4'd2, RID_DP = 4'd3,
    RID_X  = 4'd4, RID_Y = 4'd5, RID_U = 4'd6, RID_S  = 4'd7,
    RID_PC = 4'd8
  } rid_e;

  typedef enum logic [1:0] {
    ST_IDLE, ST_HEAD, ST_XFER, ST_TAIL
  } seq_st_e;

  localparam logic [7:0] OPC_PUSH_S = 8'h34;
  localparam logic [7:0] OPC_PULL_S = 8'h35;
  localparam logic [7:0] OPC_PUSH_U = 8'h36;
  localparam logic [7:0] OPC_PULL_U = 8'h37;
endpackage

// File: rtl/stk_regfile.sv
module stk_regfile
  import stk_pkg::*;
#(
  parameter  int DW = 8,
  localparam int AW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lock,
  input  logic          ld_en,
  input  logic [3:0]    ld_sel,
  input  logic [AW-1:0] ld_data,
  input  logic          bw_en,
  input  logic [3:0]    bw_sel,
  input  logic          bw_hi,
  input  logic [DW-1:0] bw_data,
  input  logic          pw_en,
  input  logic          pw_use_u,
  input  logic [AW-1:0] pw_data,
  input  logic [3:0]    rd_sel,
  output logic [AW-1:0] rd_val,
  output logic [DW-1:0] q8  [NUM_NARROW],
  output logic [AW-1:0] q16 [NUM_RID-NUM_NARROW]
);
  logic [AW-1:0] regs [NUM_RID];
  logic [3:0]    pw_sel;
  logic [NUM_RID*AW-1:0] flat;

  assign pw_sel = pw_use_u ? RID_U : RID_S;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_RID; i++) regs[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_RID; i++) begin
        if (pw_en && pw_sel == 4'(i)) begin
          regs[i] <= pw_data;
        end else if (bw_en && bw_sel == 4'(i)) begin
          if (i >= NUM_NARROW && bw_hi) regs[i][AW-1:DW] <= bw_data;
          else                          regs[i][DW-1:0]  <= bw_data;
        end else if (ld_en && !lock && ld_sel == 4'(i)) begin
          if (i >= NUM_NARROW) regs[i] <= ld_data;
          else                 regs[i] <= {{DW{1'b0}}, ld_data[DW-1:0]};
        end
      end
    end
  end

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NUM_RID; i++)
      if (rd_sel == 4'(i)) rd_val = regs[i];
  end

  for (genvar g = 0; g < NUM_RID; g++) begin : g_out
    assign flat[g*AW +: AW] = regs[g];
    if (g < NUM_NARROW) begin : g_narrow
      assign q8[g] = regs[g][DW-1:0];
    end else begin : g_wide
      assign q16[g-NUM_NARROW] = regs[g];
    end
  end

  // R9: loads are dropped while the sequencer owns the registers
  assert_ld_locked_R9: assert property (@(posedge clk) disable iff (rst)
    (ld_en && lock && !bw_en && !pw_en) |=> $stable(flat));

  // R9: an idle load lands on the next edge
  assert_ld_taken_R9: assert property (@(posedge clk) disable iff (rst)
    (ld_en && !lock && !bw_en && !pw_en && ld_sel == RID_X) |=> (regs[RID_X] == $past(ld_data)));
endmodule

// File: rtl/stk_pick.sv
module stk_pick #(
  parameter  int N  = 8,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  mask,
  input  logic          lowest_first,
  output logic [N-1:0]  oh,
  output logic [IW-1:0] idx
);
  logic [N-1:0] oh_lo, oh_hi;
  logic         seen_lo, seen_hi;

  always_comb begin
    seen_lo = 1'b0;
    for (int i = 0; i < N; i++) begin
      oh_lo[i] = mask[i] & ~seen_lo;
      seen_lo  = seen_lo | mask[i];
    end
    seen_hi = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      oh_hi[i] = mask[i] & ~seen_hi;
      seen_hi  = seen_hi | mask[i];
    end
  end

  assign oh = lowest_first ? oh_lo : oh_hi;

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++)
      if (oh[i]) idx = IW'(i);
  end
endmodule

// File: rtl/stk_seq_ctrl.sv
module stk_seq_ctrl
  import stk_pkg::*;
#(
  parameter  int DW       = 8,
  parameter  int BASE_CYC = 5,
  localparam int AW       = 2 * DW,
  localparam int TW       = $clog2(BASE_CYC + 3 * MASK_W / 2 + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [7:0]        opcode,
  input  logic [MASK_W-1:0] postbyte,
  input  logic [AW-1:0]     sp_s,
  input  logic [AW-1:0]     sp_u,
  input  logic [AW-1:0]     rd_val,
  input  logic [DW-1:0]     mem_rdata,
  output logic [3:0]        rd_sel,
  output logic              busy,
  output logic              done,
  output logic [TW-1:0]     cyc_total,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  output logic              mem_we,
  output logic              bw_en,
  output logic [3:0]        bw_sel,
  output logic              bw_hi,
  output logic [DW-1:0]     bw_data,
  output logic              pw_en,
  output logic              pw_use_u,
  output logic [AW-1:0]     pw_data
);
  localparam int HEAD_CYC = BASE_CYC - 1;
  localparam int HW       = $clog2(HEAD_CYC + 1);
  localparam int IW       = $clog2(MASK_W);
  localparam int WIDE_LO  = MASK_W / 2;

  seq_st_e           st;
  logic [HW-1:0]     hcnt;
  logic [MASK_W-1:0] mask;
  logic              half, pull_q, useu_q;
  logic [AW-1:0]     ptr;
  logic [TW-1:0]     run_cnt;

  logic [MASK_W-1:0] pick_oh;
  logic [IW-1:0]     pick_idx;
  logic              is_pull, is_u, valid_op;
  logic              is16, take_hi, last_of_reg;
  logic [MASK_W-1:0] mask_after;
  logic [3:0]        cur_id;

  function automatic logic [TW-1:0] count_bytes(input logic [MASK_W-1:0] pb);
    int n;
    n = 0;
    for (int i = 0; i < MASK_W; i++)
      if (pb[i]) n += (i >= WIDE_LO) ? 2 : 1;
    return TW'(n);
  endfunction

  stk_pick #(.N(MASK_W)) u_pick (
    .mask         (mask),
    .lowest_first (pull_q),
    .oh           (pick_oh),
    .idx          (pick_idx)
  );

  assign is_pull  = (opcode == OPC_PULL_S) || (opcode == OPC_PULL_U);
  assign is_u     = (opcode == OPC_PUSH_U) || (opcode == OPC_PULL_U);
  assign valid_op = is_pull || (opcode == OPC_PUSH_S) || (opcode == OPC_PUSH_U);

  always_comb begin
    case (pick_idx)
      3'd6:    cur_id = useu_q ? RID_S : RID_U;
      3'd7:    cur_id = RID_PC;
      default: cur_id = {1'b0, pick_idx};
    endcase
  end

  assign is16        = (int'(pick_idx) >= WIDE_LO);
  assign take_hi     = pull_q ? ~half : half;
  assign last_of_reg = !is16 || half;
  assign mask_after  = mask & ~pick_oh;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      hcnt      <= '0;
      mask      <= '0;
      half      <= 1'b0;
      pull_q    <= 1'b0;
      useu_q    <= 1'b0;
      ptr       <= '0;
      cyc_total <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start && valid_op) begin
          st        <= ST_HEAD;
          hcnt      <= HW'(HEAD_CYC - 1);
          mask      <= postbyte;
          half      <= 1'b0;
          pull_q    <= is_pull;
          useu_q    <= is_u;
          ptr       <= is_u ? sp_u : sp_s;
          cyc_total <= TW'(BASE_CYC) + count_bytes(postbyte);
        end
        ST_HEAD: begin
          if (hcnt == '0) st <= (mask == '0) ? ST_TAIL : ST_XFER;
          else            hcnt <= hcnt - HW'(1);
        end
        ST_XFER: begin
          ptr <= pull_q ? ptr + AW'(1) : ptr - AW'(1);
          if (last_of_reg) begin
            mask <= mask_after;
            half <= 1'b0;
            if (mask_after == '0) st <= ST_TAIL;
          end else begin
            half <= 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || st == ST_IDLE) run_cnt <= '0;
    else                      run_cnt <= run_cnt + TW'(1);
  end

  assign busy      = (st != ST_IDLE);
  assign done      = (st == ST_TAIL);
  assign rd_sel    = cur_id;
  assign mem_addr  = pull_q ? ptr : ptr - AW'(1);
  assign mem_wdata = (take_hi && is16) ? rd_val[AW-1:DW] : rd_val[DW-1:0];
  assign mem_we    = (st == ST_XFER) && !pull_q;
  assign bw_en     = (st == ST_XFER) && pull_q;
  assign bw_sel    = cur_id;
  assign bw_hi     = take_hi && is16;
  assign bw_data   = mem_rdata;
  assign pw_en     = (st == ST_TAIL);
  assign pw_use_u  = useu_q;
  assign pw_data   = ptr;

  // R1: unknown opcodes leave the sequencer idle
  assert_bad_op_R1: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && start && !valid_op) |=> (st == ST_IDLE));

  // R2: the final cycle matches the announced length
  assert_len_R2: assert property (@(posedge clk) disable iff (rst)
    (st == ST_TAIL) |-> (run_cnt == cyc_total - TW'(1)));

  // R3: exactly one register is selected in every transfer cycle
  assert_pick_onehot_R3: assert property (@(posedge clk) disable iff (rst)
    (st == ST_XFER) |-> $onehot(pick_oh));

  // R4: push moves the pointer down one byte per transfer
  assert_psh_step_R4: assert property (@(posedge clk) disable iff (rst)
    (st == ST_XFER && !pull_q) |=> (ptr == $past(ptr) - AW'(1)));

  // R5: pull moves the pointer up one byte per transfer
  assert_pul_step_R5: assert property (@(posedge clk) disable iff (rst)
    (st == ST_XFER && pull_q) |=> (ptr == $past(ptr) + AW'(1)));

  // R7: an empty mask skips the transfer phase
  assert_empty_R7: assert property (@(posedge clk) disable iff (rst)
    (st == ST_HEAD && hcnt == '0 && mask == '0) |=> (st == ST_TAIL));
endmodule

// File: rtl/stk_pushpull.sv
module stk_pushpull
  import stk_pkg::*;
#(
  parameter  int DW       = 8,
  parameter  int BASE_CYC = 5,
  localparam int AW       = 2 * DW,
  localparam int TW       = $clog2(BASE_CYC + 3 * MASK_W / 2 + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [7:0]        opcode,
  input  logic [MASK_W-1:0] postbyte,
  output logic              busy,
  output logic              done,
  output logic [TW-1:0]     cycles,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  output logic              mem_we,
  input  logic [DW-1:0]     mem_rdata,
  input  logic              ld_en,
  input  logic [3:0]        ld_sel,
  input  logic [AW-1:0]     ld_data,
  output logic [DW-1:0]     reg_a,
  output logic [DW-1:0]     reg_b,
  output logic [DW-1:0]     reg_cc,
  output logic [DW-1:0]     reg_dp,
  output logic [AW-1:0]     reg_x,
  output logic [AW-1:0]     reg_y,
  output logic [AW-1:0]     reg_u,
  output logic [AW-1:0]     reg_s,
  output logic [AW-1:0]     reg_pc
);
  logic [DW-1:0] q8  [NUM_NARROW];
  logic [AW-1:0] q16 [NUM_RID-NUM_NARROW];
  logic [AW-1:0] rd_val;
  logic [3:0]    rd_sel, bw_sel;
  logic          bw_en, bw_hi, pw_en, pw_use_u;
  logic [DW-1:0] bw_data;
  logic [AW-1:0] pw_data;

  stk_seq_ctrl #(.DW(DW), .BASE_CYC(BASE_CYC)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .opcode    (opcode),
    .postbyte  (postbyte),
    .sp_s      (reg_s),
    .sp_u      (reg_u),
    .rd_val    (rd_val),
    .mem_rdata (mem_rdata),
    .rd_sel    (rd_sel),
    .busy      (busy),
    .done      (done),
    .cyc_total (cycles),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .bw_en     (bw_en),
    .bw_sel    (bw_sel),
    .bw_hi     (bw_hi),
    .bw_data   (bw_data),
    .pw_en     (pw_en),
    .pw_use_u  (pw_use_u),
    .pw_data   (pw_data)
  );

  stk_regfile #(.DW(DW)) u_rf (
    .clk      (clk),
    .rst      (rst),
    .lock     (busy),
    .ld_en    (ld_en),
    .ld_sel   (ld_sel),
    .ld_data  (ld_data),
    .bw_en    (bw_en),
    .bw_sel   (bw_sel),
    .bw_hi    (bw_hi),
    .bw_data  (bw_data),
    .pw_en    (pw_en),
    .pw_use_u (pw_use_u),
    .pw_data  (pw_data),
    .rd_sel   (rd_sel),
    .rd_val   (rd_val),
    .q8       (q8),
    .q16      (q16)
  );

  assign reg_cc = q8[RID_CC];
  assign reg_a  = q8[RID_A];
  assign reg_b  = q8[RID_B];
  assign reg_dp = q8[RID_DP];
  assign reg_x  = q16[RID_X  - NUM_NARROW];
  assign reg_y  = q16[RID_Y  - NUM_NARROW];
  assign reg_u  = q16[RID_U  - NUM_NARROW];
  assign reg_s  = q16[RID_S  - NUM_NARROW];
  assign reg_pc = q16[RID_PC - NUM_NARROW];
endmodule

// File: tb/sim_stk_pushpull.sv
module sim_stk_pushpull;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic        start = 1'b0;
  logic [7:0]  opcode = '0, postbyte = '0;
  logic        busy, done, mem_we;
  logic [4:0]  cycles;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        ld_en = 1'b0;
  logic [3:0]  ld_sel = '0;
  logic [15:0] ld_data = '0;
  logic [7:0]  reg_a, reg_b, reg_cc, reg_dp;
  logic [15:0] reg_x, reg_y, reg_u, reg_s, reg_pc;

  stk_pushpull u0 (
    .clk(clk), .rst(rst), .start(start), .opcode(opcode), .postbyte(postbyte),
    .busy(busy), .done(done), .cycles(cycles),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_rdata(mem_rdata),
    .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
    .reg_a(reg_a), .reg_b(reg_b), .reg_cc(reg_cc), .reg_dp(reg_dp),
    .reg_x(reg_x), .reg_y(reg_y), .reg_u(reg_u), .reg_s(reg_s), .reg_pc(reg_pc)
  );

  logic [7:0] mem  [0:1023];
  logic [7:0] emem [0:1023];
  assign mem_rdata = mem[mem_addr[9:0]];
  always @(posedge clk) if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;

  int checks = 0, fails = 0;
  int m [9];

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int dut_reg(input int id);
    case (id)
      0: return int'(reg_cc);
      1: return int'(reg_a);
      2: return int'(reg_b);
      3: return int'(reg_dp);
      4: return int'(reg_x);
      5: return int'(reg_y);
      6: return int'(reg_u);
      7: return int'(reg_s);
      default: return int'(reg_pc);
    endcase
  endfunction

  function automatic int bit2id(input int b, input bit useu);
    if (b == 6) return useu ? 7 : 6;
    if (b == 7) return 8;
    return b;
  endfunction

  task automatic check_regs(input string tag);
    for (int id = 0; id < 9; id++)
      chk((id == 6 || id == 7) ? "R6" : tag, $sformatf("reg%0d", id), dut_reg(id), m[id]);
  endtask

  task automatic load(input int id, input int val);
    @(negedge clk);
    ld_en = 1'b1; ld_sel = 4'(id); ld_data = 16'(val);
    @(negedge clk);
    ld_en = 1'b0;
    m[id] = (id < 4) ? (val & 'hFF) : (val & 'hFFFF);
    chk("R9", $sformatf("load reg%0d", id), dut_reg(id), m[id]);
  endtask

  task automatic do_op(input logic [7:0] opc, input logic [7:0] pb,
                       input bit inj_start, input bit inj_ld);
    int qa[$]; int qd[$];
    int sp, id, v, hi, lo, n, total;
    bit pull, useu;
    pull = (opc == 8'h35) || (opc == 8'h37);
    useu = (opc == 8'h36) || (opc == 8'h37);
    sp = useu ? m[6] : m[7];
    if (!pull) begin
      for (int b = 7; b >= 0; b--) if (pb[b]) begin
        id = bit2id(b, useu); v = m[id];
        sp = (sp - 1) & 'hFFFF; qa.push_back(sp); qd.push_back(v & 'hFF);
        emem[sp & 1023] = 8'(v);
        if (b >= 4) begin
          sp = (sp - 1) & 'hFFFF; qa.push_back(sp); qd.push_back((v >> 8) & 'hFF);
          emem[sp & 1023] = 8'(v >> 8);
        end
      end
    end else begin
      for (int b = 0; b < 8; b++) if (pb[b]) begin
        id = bit2id(b, useu);
        if (b >= 4) begin
          qa.push_back(sp); qd.push_back(0); hi = emem[sp & 1023]; sp = (sp + 1) & 'hFFFF;
          qa.push_back(sp); qd.push_back(0); lo = emem[sp & 1023]; sp = (sp + 1) & 'hFFFF;
          m[id] = hi * 256 + lo;
        end else begin
          qa.push_back(sp); qd.push_back(0); m[id] = emem[sp & 1023]; sp = (sp + 1) & 'hFFFF;
        end
      end
    end
    if (useu) m[6] = sp; else m[7] = sp;
    n = qa.size();
    total = 5 + n;

    @(negedge clk);
    start = 1'b1; opcode = opc; postbyte = pb;
    for (int k = 0; k <= total; k++) begin
      @(negedge clk);
      chk("R2", $sformatf("busy k=%0d", k), busy, (k < total));
      chk("R2", $sformatf("done k=%0d", k), done, (k == total - 1));
      if (k == 0) chk("R2", "cycles", cycles, total);
      if (k >= 4 && k < 4 + n) begin
        chk(pull ? "R5" : "R4", $sformatf("we k=%0d", k), mem_we, !pull);
        chk(pull ? "R5" : "R4", $sformatf("addr k=%0d", k), mem_addr, qa[k-4]);
        if (!pull) chk("R4", $sformatf("wdata k=%0d", k), mem_wdata, qd[k-4]);
      end else begin
        chk(n == 0 ? "R7" : "R2", $sformatf("idle we k=%0d", k), mem_we, 0);
      end
      if (k == 0) start = 1'b0;
      if (k == 1) begin
        if (inj_start) begin start = 1'b1; opcode = 8'h34; postbyte = 8'hFF; end
        if (inj_ld)    begin ld_en = 1'b1; ld_sel = 4'd1; ld_data = 16'h0099; end
      end
      if (k == 2) begin start = 1'b0; ld_en = 1'b0; end
    end
    check_regs(pull ? "R5" : "R4");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) begin
      mem[i] = 8'(i ^ 'h5A); emem[i] = 8'(i ^ 'h5A);
    end
    for (int i = 0; i < 9; i++) m[i] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10", "busy", busy, 0);
    chk("R10", "done", done, 0);
    chk("R10", "we", mem_we, 0);
    chk("R10", "cycles", cycles, 0);
    check_regs("R10");

    load(0, 'h33); load(1, 'h11); load(2, 'h22); load(3, 'h44);
    load(4, 'h1234); load(5, 'h5678); load(6, 'h0300); load(7, 'h0100); load(8, 'hABCD);
    load(2, 'h7722);

    // full push and pull on S
    do_op(8'h34, 8'hFF, 1'b0, 1'b0);
    chk("R8", "U stored on S stack hi", mem[10'h100 - 10'd4], 8'h03);
    chk("R8", "U stored on S stack lo", mem[10'h100 - 10'd3], 8'h00);
    load(1, 'h00); load(4, 'h0000); load(6, 'h0111); load(8, 'h0000);
    do_op(8'h35, 8'hFF, 1'b0, 1'b0);
    chk("R8", "U restored from S stack", reg_u, 16'h0300);

    // mixed mask on U with injected start and load during busy
    do_op(8'h36, 8'h96, 1'b1, 1'b1);
    chk("R1", "start while busy ignored, S", reg_s, 16'(m[7]));
    chk("R9", "load while busy ignored, A", reg_a, 8'(m[1]));
    load(4, 'hBEEF);
    do_op(8'h37, 8'h96, 1'b0, 1'b0);

    // push of A only, load of A during busy must not alter the pushed byte
    do_op(8'h34, 8'h02, 1'b0, 1'b1);
    chk("R9", "A unchanged after busy load", reg_a, 8'(m[1]));

    // single CC on S
    do_op(8'h34, 8'h01, 1'b0, 1'b0);
    chk("R3", "bit0 pushes CC", mem[10'(m[7])], 8'(m[0]));

    // empty masks
    do_op(8'h34, 8'h00, 1'b0, 1'b0);
    do_op(8'h37, 8'h00, 1'b0, 1'b0);

    // invalid opcode
    @(negedge clk);
    start = 1'b1; opcode = 8'h33; postbyte = 8'hFF;
    @(negedge clk);
    start = 1'b0;
    chk("R1", "bad opcode busy", busy, 0);
    @(negedge clk);
    chk("R1", "bad opcode we", mem_we, 0);
    check_regs("R1");

    // single-bit sweep on U
    for (int b = 0; b < 8; b++) begin
      do_op(8'h36, 8'(1 << b), 1'b0, 1'b0);
      load(bit2id(b, 1'b1), (b == 6) ? 'h0155 : 'h00A5);
      do_op(8'h37, 8'(1 << b), 1'b0, 1'b0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule